// File: doc/BRIEF.md
# Module power state controller

This block sits beside a set of up to 32 peripheral modules and decides, for each of them, whether its clock runs and whether it is held in reset. Software writes a desired next state into a per-module control word. Nothing happens at that point. Only when software writes the transition command do all pending next states take effect together, in the same clock cycle. A global busy flag shows that a transition is still settling, and software polls it before it issues the next command.

Each state is a 2-bit pair made of a clock enable and an active-low reset. One transition is not immediate. When a module goes from enabled to reset-with-clock-gated, its reset asserts first, and its clock keeps running for a fixed number of cycles before it is gated. This lets the module's synchronous reset take hold before the clock stops. A read-only status word per module reports the pair that the module currently sees.

Register map (word aligned, address bits 1:0 ignored, 10-bit address): 0x000 command, 0x004 global status, 0x100 + 4*m next-state control of module m, 0x200 + 4*m current state of module m. Every other address is unmapped.

Top module: `modpwr_ctrl`

## Requirements
- R1: After reset every module has its clock enable at 0 and its reset output at 0, every next-state field reads 0, and the busy bit reads 0.
- R2: A write to 0x100 + 4*m stores bits 4:0 of the write data as module m's next state, which reads back in bits 4:0 with all upper bits 0. The write alone changes no output.
- R3: Writing 1 in bit 0 of the command word at 0x000 while not busy applies each module's pending next state. The new outputs appear on the clock edge that samples the write.
- R4: State codes map to outputs as follows: 0 gives clock off and in reset, 1 gives clock on and in reset, 2 gives clock off and out of reset, 3 gives clock on and out of reset. Bit 0 of the code is the clock enable and bit 1 is the reset release.
- R5: Next-state codes 4 to 31 are stored and read back. A command leaves such a module in its current state.
- R6: For a module going from code 3 to code 0, reset asserts at the command edge and the clock stays enabled for HOLD_CYC (4) more cycles. The clock is gated at the HOLD_CYC-th edge after the command. Every other change, including 1 to 0, takes effect in full at the command edge.
- R7: Bit 0 of 0x004 reads 1 from the command edge onward. It clears 1 cycle later when no module holds its clock, and HOLD_CYC+1 cycles later when any module does.
- R8: A command written while busy is ignored. Next-state writes made while busy are kept and apply at the next accepted command.
- R9: The word at 0x200 + 4*m reads 2*reset_release + clock_enable of module m in bits 1:0.
- R10: Writes to 0x004, to the current-state words, to unmapped addresses, and command writes with bit 0 at 0 change nothing. Unmapped reads, including module indices at or above NUM_MODS, return 0.
- R11: One command moves several modules to different states in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 10 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mod_clk_en | output | NUM_MODS | Per-module clock enable |
| mod_rst_n | output | NUM_MODS | Per-module active-low reset |

## Verification
Read data is combinational, so a read is due in the same cycle its address is driven. Output pairs and next-state fields change on the edge that samples the write. The busy bit rises at that edge and falls 1 or HOLD_CYC+1 edges later. A held clock drops exactly HOLD_CYC edges after the command. The bench drives inputs on the falling edge, advances its reference model on the rising edge, and compares all outputs a quarter period after each falling edge. Every result is therefore taken one sampled edge after the stimulus that caused it. The directed checks count falling edges from the command write to hit the first cycle of each result and the cycle where it ends.

// File: rtl/modpwr_pkg.sv
// Shared constants and types of the module power state controller.
// Assumes a 10-bit word-aligned byte address split as region[9:8], index[7:2].
package modpwr_pkg;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int NS_W   = 5;
    localparam int IDX_W  = 6;

    typedef enum logic [1:0] {
        REG_GLOBAL = 2'd0,
        REG_NEXT   = 2'd1,
        REG_CUR    = 2'd2,
        REG_NONE   = 2'd3
    } region_e;

    localparam logic [NS_W-1:0] ST_OFF  = 5'd0;
    localparam logic [NS_W-1:0] ST_SRST = 5'd1;
    localparam logic [NS_W-1:0] ST_DIS  = 5'd2;
    localparam logic [NS_W-1:0] ST_ON   = 5'd3;

    localparam logic [IDX_W-1:0] IDX_CMD  = 6'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 6'd1;

    // True when a next-state code names one of the four defined states.
    function automatic logic code_valid(input logic [NS_W-1:0] code);
        return code <= ST_ON;
    endfunction
endpackage

// File: rtl/modpwr_slot.sv
// One module's slot: next-state field, current clock/reset pair, clock-hold timer.
// Assumes go is only raised when no slot is holding its clock.
module modpwr_slot import modpwr_pkg::*; #(
    parameter int HOLD_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_we,
    input  logic [NS_W-1:0] ctl_wdata,
    input  logic            go,
    output logic [NS_W-1:0] ns_o,
    output logic            clk_en_o,
    output logic            rst_n_o,
    output logic            hold_o
);
    localparam int CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC - 1);

    logic [NS_W-1:0]  ns_q;
    logic             clk_en_q;
    logic             rstn_q;
    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_on;
    logic             code_ok;
    logic             need_hold;

    assign is_on     = clk_en_q & rstn_q;
    assign code_ok   = code_valid(ns_q);
    assign need_hold = is_on & (ns_q == ST_OFF);

    // Stores the pending next-state code written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q <= ST_OFF;
        end else if (ctl_we) begin
            ns_q <= ctl_wdata;
        end
    end

    // Applies the pending code on go, or runs down the clock-hold window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            rstn_q   <= 1'b0;
            hold_q   <= 1'b0;
            cnt_q    <= '0;
        end else if (hold_q) begin
            if (cnt_q == '0) begin
                clk_en_q <= 1'b0;
                hold_q   <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (go && code_ok) begin
            if (need_hold) begin
                rstn_q <= 1'b0;
                hold_q <= 1'b1;
                cnt_q  <= CNT_LOAD;
            end else begin
                clk_en_q <= ns_q[0];
                rstn_q   <= ns_q[1];
            end
        end
    end

    assign ns_o     = ns_q;
    assign clk_en_o = clk_en_q;
    assign rst_n_o  = rstn_q;
    assign hold_o   = hold_q;

    // R6: a hold window only opens from the enabled state.
    assert_hold_from_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> $past(clk_en_q && rstn_q));

    // R6: during the hold window the clock runs while reset is asserted.
    assert_hold_clock_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (clk_en_q && !rstn_q));

    // R2: outputs move only after go or during a hold window.
    assert_quiet_without_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(go) && !$past(hold_q)) |-> ($stable(clk_en_q) && $stable(rstn_q)));

    // R5: an undefined code leaves the outputs unchanged at go.
    assert_bad_code_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(go) && !$past(hold_q) && ($past(ns_q) > ST_ON))
            |-> ($stable(clk_en_q) && $stable(rstn_q)));
endmodule

// File: rtl/modpwr_seq.sv
// Transition sequencer: accepts a command when idle and keeps busy until holds end.
// Assumes any_hold comes from registered slot state.
module modpwr_seq import modpwr_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic go_bit,
    input  logic any_hold,
    output logic go_accept,
    output logic busy
);
    logic busy_q;

    assign go_accept = cmd_we & go_bit & ~busy_q;

    // Sets busy on an accepted command, clears it once no slot holds its clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (go_accept) begin
            busy_q <= 1'b1;
        end else if (busy_q && !any_hold) begin
            busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;

    // R7: busy only rises after a command write with bit 0 set.
    assert_busy_needs_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(cmd_we && go_bit));

    // R7: busy stays up while any slot holds its clock.
    assert_busy_covers_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && any_hold) |=> busy_q);

    // R8: once holds are over, busy drops even if a command was written.
    assert_cmd_ignored_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !any_hold) |=> !busy_q);
endmodule

// File: rtl/modpwr_rdmux.sv
// Read multiplexer for the register map; unmapped words read zero.
// Assumes NUM_MODS is at most 64, the size of the index field.
module modpwr_rdmux import modpwr_pkg::*; #(
    parameter int NUM_MODS = 32
) (
    input  region_e                         region,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            busy,
    input  logic [NUM_MODS-1:0][NS_W-1:0]   ns_all,
    input  logic [NUM_MODS-1:0]             clk_all,
    input  logic [NUM_MODS-1:0]             rstn_all,
    output logic [DATA_W-1:0]               rdata
);
    // Selects the addressed word by region and index.
    always_comb begin
        rdata = '0;
        case (region)
            REG_GLOBAL: begin
                if (idx == IDX_STAT) rdata[0] = busy;
            end
            REG_NEXT: begin
                for (int m = 0; m < NUM_MODS; m++) begin
                    if (idx == IDX_W'(m)) rdata[NS_W-1:0] = ns_all[m];
                end
            end
            REG_CUR: begin
                for (int m = 0; m < NUM_MODS; m++) begin
                    if (idx == IDX_W'(m)) rdata[1:0] = {rstn_all[m], clk_all[m]};
                end
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/modpwr_ctrl.sv
// Module power state controller top: address decode, per-module slots,
// transition sequencer and read mux. Assumes single-cycle writes and
// combinational reads; address bits 1:0 are ignored.
module modpwr_ctrl import modpwr_pkg::*; #(
    parameter int NUM_MODS = 32,
    parameter int HOLD_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_MODS-1:0] mod_clk_en,
    output logic [NUM_MODS-1:0] mod_rst_n
);
    region_e                       region;
    logic [IDX_W-1:0]              idx;
    logic                          cmd_we;
    logic                          go_accept;
    logic                          busy;
    logic                          any_hold;
    logic [NUM_MODS-1:0]           hold_vec;
    logic [NUM_MODS-1:0][NS_W-1:0] ns_all;
    logic                          unused_bits;

    assign region      = region_e'(bus_addr[ADDR_W-1:ADDR_W-2]);
    assign idx         = bus_addr[IDX_W+1:2];
    assign cmd_we      = bus_wr && (region == REG_GLOBAL) && (idx == IDX_CMD);
    assign any_hold    = |hold_vec;
    assign unused_bits = ^{bus_wdata[DATA_W-1:NS_W], bus_addr[1:0]};

    modpwr_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .go_bit    (bus_wdata[0]),
        .any_hold  (any_hold),
        .go_accept (go_accept),
        .busy      (busy)
    );

    for (genvar g = 0; g < NUM_MODS; g++) begin : g_slot
        logic ctl_we;
        assign ctl_we = bus_wr && (region == REG_NEXT) && (idx == IDX_W'(g));

        modpwr_slot #(.HOLD_CYC(HOLD_CYC)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we),
            .ctl_wdata (bus_wdata[NS_W-1:0]),
            .go        (go_accept),
            .ns_o      (ns_all[g]),
            .clk_en_o  (mod_clk_en[g]),
            .rst_n_o   (mod_rst_n[g]),
            .hold_o    (hold_vec[g])
        );
    end

    modpwr_rdmux #(.NUM_MODS(NUM_MODS)) i_rdmux (
        .region   (region),
        .idx      (idx),
        .busy     (busy),
        .ns_all   (ns_all),
        .clk_all  (mod_clk_en),
        .rstn_all (mod_rst_n),
        .rdata    (bus_rdata)
    );

    // R10: unmapped region reads zero.
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (region == REG_NONE) |-> (bus_rdata == '0));

    // R3: an accepted command always raises busy on the next cycle.
    assert_go_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        go_accept |=> busy);
endmodule

// File: tb/test_modpwr_ctrl.sv
// Bench: behavioural reference model advanced on rising edges, full output
// compare each cycle, plus directed checks per requirement.
module test_modpwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 32;
    localparam int HOLD = 4;
    localparam int Q    = CLK_PERIOD / 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  mod_clk_en;
    logic [N-1:0]  mod_rst_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit live   = 0;

    int m_ns [N];
    bit m_clk[N];
    bit m_rst[N];
    int m_h  [N];
    bit m_busy;

    modpwr_ctrl #(.NUM_MODS(N), .HOLD_CYC(HOLD)) i_modpwr_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] a_ns(input int m);
        return 10'h100 + 10'(4 * m);
    endfunction

    function automatic logic [9:0] a_st(input int m);
        return 10'h200 + 10'(4 * m);
    endfunction

    function automatic logic [31:0] model_rd(input logic [9:0] a);
        int i;
        i = int'(a[7:2]);
        case (a[9:8])
            2'd0: return (i == 1) ? {31'd0, m_busy} : 32'd0;
            2'd1: return (i < N) ? 32'(m_ns[i]) : 32'd0;
            2'd2: return (i < N) ? {30'd0, m_rst[i], m_clk[i]} : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int m = 0; m < N; m++) begin
                m_ns[m] = 0; m_clk[m] = 0; m_rst[m] = 0; m_h[m] = 0;
            end
            m_busy = 0;
        end else begin
            bit anyh;
            bit goa;
            anyh = 0;
            for (int m = 0; m < N; m++) if (m_h[m] > 0) anyh = 1;
            goa = bus_wr && bus_addr[9:2] == 8'd0 && bus_wdata[0] && !m_busy;
            for (int m = 0; m < N; m++) begin
                if (m_h[m] > 0) begin
                    m_h[m]--;
                    if (m_h[m] == 0) m_clk[m] = 0;
                end else if (goa && m_ns[m] <= 3) begin
                    if (m_clk[m] && m_rst[m] && m_ns[m] == 0) begin
                        m_rst[m] = 0;
                        m_h[m] = HOLD;
                    end else begin
                        m_clk[m] = m_ns[m][0];
                        m_rst[m] = m_ns[m][1];
                    end
                end
            end
            if (goa) m_busy = 1;
            else if (m_busy && !anyh) m_busy = 0;
            if (bus_wr && bus_addr[9:8] == 2'd1 && int'(bus_addr[7:2]) < N)
                m_ns[int'(bus_addr[7:2])] = int'(bus_wdata[4:0]);
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        #Q;
        if (live) begin
            logic [N-1:0] ec, er;
            for (int m = 0; m < N; m++) begin
                ec[m] = m_clk[m];
                er[m] = m_rst[m];
            end
            chk(mod_clk_en == ec, "R3 clock enables vs model", mod_clk_en, ec);
            chk(mod_rst_n == er, "R4 resets vs model", mod_rst_n, er);
            chk(bus_rdata == model_rd(bus_addr), "R9 read data vs model", bus_rdata, model_rd(bus_addr));
        end
    end

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
        #(Q + 1);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic step();
        @(negedge clk);
        bus_wr = 1'b0;
        #(Q + 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        // R1: reset state
        rd(10'h004, 32'd0, "R1 busy after reset");
        chk(mod_clk_en == '0, "R1 clocks off", mod_clk_en, 0);
        chk(mod_rst_n == '0, "R1 resets asserted", mod_rst_n, 0);
        rd(a_ns(4), 32'd0, "R1 next-state field");

        // R2 / R5: program pending states
        wr(a_ns(0), 32'd3);
        wr(a_ns(1), 32'd1);
        wr(a_ns(2), 32'd2);
        wr(a_ns(3), 32'hFFFF_FFE2);
        wr(a_ns(5), 32'd3);
        wr(a_ns(7), 32'd31);
        rd(a_ns(3), 32'd2, "R2 upper bits dropped");
        rd(a_ns(7), 32'd31, "R5 bad code stored");
        chk(mod_clk_en == '0 && mod_rst_n == '0, "R2 no effect before command", {mod_clk_en[15:0], mod_rst_n[15:0]}, 0);

        // R3 R4 R11: apply together
        wr(10'h000, 32'd1);
        rd(10'h004, 32'd1, "R7 busy after command");
        chk(mod_clk_en == 32'h0000_0023, "R11 clock enables", mod_clk_en, 32'h23);
        chk(mod_rst_n == 32'h0000_002D, "R4 resets", mod_rst_n, 32'h2D);
        rd(10'h004, 32'd0, "R7 busy one cycle");
        rd(a_st(1), 32'd1, "R9 state of module 1");
        rd(a_st(2), 32'd2, "R9 state of module 2");
        rd(a_st(0), 32'd3, "R9 state of module 0");
        rd(a_st(7), 32'd0, "R5 bad code kept state");

        // R6 R7 R8: hold window
        wr(a_ns(0), 32'd0);
        wr(a_ns(5), 32'd0);
        wr(10'h000, 32'd1);
        wr(a_ns(2), 32'd3);
        #(Q + 1);
        chk(mod_clk_en[0] == 1'b1 && mod_rst_n[0] == 1'b0, "R6 reset first, clock on", {mod_clk_en[0], mod_rst_n[0]}, 2'b10);
        wr(10'h000, 32'd1);
        #(Q + 1);
        chk(mod_clk_en[5] == 1'b1, "R6 clock held", mod_clk_en[5], 1);
        rd(10'h004, 32'd1, "R7 busy during hold");
        chk(mod_clk_en[0] == 1'b1, "R6 clock held third cycle", mod_clk_en[0], 1);
        step();
        chk(mod_clk_en[0] == 1'b1, "R6 clock held fourth cycle", mod_clk_en[0], 1);
        chk(bus_rdata == 32'd1, "R7 busy fourth cycle", bus_rdata, 1);
        step();
        chk(mod_clk_en[0] == 1'b0 && mod_clk_en[5] == 1'b0, "R6 clock gated after hold", {mod_clk_en[5], mod_clk_en[0]}, 0);
        chk(bus_rdata == 32'd1, "R7 busy last cycle", bus_rdata, 1);
        step();
        chk(bus_rdata == 32'd0, "R7 busy cleared", bus_rdata, 0);
        chk(mod_clk_en[2] == 1'b0, "R8 command during busy ignored", mod_clk_en[2], 0);
        wr(10'h000, 32'd1);
        step();
        chk(mod_clk_en == 32'h6 && mod_rst_n == 32'hC, "R8 pending write applied later", {mod_clk_en[15:0], mod_rst_n[15:0]}, {16'h6, 16'hC});
        rd(a_st(0), 32'd0, "R9 state after hold");

        // R10: ignored writes and unmapped reads
        wr(10'h004, 32'd1);
        rd(10'h004, 32'd0, "R10 status write ignored");
        wr(a_st(1), 32'd3);
        rd(a_st(1), 32'd1, "R10 state word write ignored");
        wr(10'h300, 32'd5);
        rd(10'h300, 32'd0, "R10 unmapped reads zero");
        rd(a_ns(40), 32'd0, "R10 index beyond modules");
        wr(a_ns(1), 32'd2);
        wr(10'h000, 32'd2);
        step();
        chk(mod_rst_n[1] == 1'b0 && mod_clk_en[1] == 1'b1, "R10 command without bit 0", {mod_clk_en[1], mod_rst_n[1]}, 2'b10);
        rd(10'h004, 32'd0, "R10 no busy without bit 0");

        // R6: reset-with-clock to off is immediate
        wr(a_ns(1), 32'd0);
        wr(10'h000, 32'd1);
        rd(10'h004, 32'd1, "R7 busy for immediate change");
        chk(mod_clk_en[1] == 1'b0 && mod_rst_n[1] == 1'b0, "R6 no hold from state 1", {mod_clk_en[1], mod_rst_n[1]}, 0);
        rd(10'h004, 32'd0, "R7 busy one cycle without hold");

        repeat (3) step();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule